// File: doc/BRIEF.md
# Timekeeper Interrupt Status Register

This block holds the interrupt flags of a timekeeper and drives its interrupt request. There are two event sources, an alarm match and an update-ended event. Each arrives as a one-cycle pulse. Each source has its own flag, and the flag sets whatever the state of that source's enable bit. The enable bits come from a control register. The request bit, and the interrupt output that follows it, go high while any source has both its flag and its enable set.

The host reads the status byte with a read strobe, and reading clears the byte. The value returned is captured on the first cycle the strobe is high. It stays frozen until the strobe falls. On the cycle after the strobe falls, exactly the flags shown in that captured value are cleared. Events that arrive while the strobe is high are parked in a second latch stage. They are posted to the flags in that same clear cycle, so no event is lost across a read.

Top module: `isr_status`

## Requirements
- R1: A one-cycle pulse on `alarm_evt` or `upd_evt` sets the matching flag after the next clock edge whatever its enable bit. The alarm flag is status bit 5 and the update-ended flag is status bit 4.
- R2: `irq` is 1 whenever at least one source has both its flag and its enable set. Outside a read, status bit 7 equals `irq`.
- R3: When a flag is already 1 and its enable goes to 1, `irq` rises in that same cycle, with no clock edge needed.
- R4: Status bits 6, 3, 2, 1 and 0 always read 0.
- R5: On the first cycle `rd_stb` is high, `status` shows the live value. From the next cycle until the strobe falls, `status` holds that value unchanged.
- R6: In the cycle after `rd_stb` falls, every flag that was 1 in the captured value is cleared. Bit 7 clears with it unless a posted event re-raises it.
- R7: An event that arrives while `rd_stb` is high does not change `status` during the read. It appears as a set flag after the clear.
- R8: An event that arrives in the clear cycle, the cycle after the strobe falls, is set after the clear.
- R9: Both flags can be 1 in one captured value, and one read clears both.
- R10: While `rst_n` is low, the flags, the held events and the read state are 0, so `status` is 0x00 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_evt | input | 1 | Alarm-match event pulse |
| upd_evt | input | 1 | Update-ended event pulse |
| alarm_en | input | 1 | Alarm interrupt enable |
| upd_en | input | 1 | Update-ended interrupt enable |
| rd_stb | input | 1 | Status read strobe, high for one or more cycles |
| status | output | 8 | Status byte: bit 7 request, bit 5 alarm, bit 4 update-ended |
| irq | output | 1 | Active-high interrupt request |

## Verification
An event is due one clock edge after its pulse. Enable changes reach `irq` in the same cycle because that path has no register. A capture shows on `status` one edge after the strobe first rises, and the clear and the posting of held events show one edge after the strobe falls. The bench drives every input on the falling clock edge and checks one falling edge later, after exactly one rising edge. Each expected value in the vector table is therefore the state after one register update, with that row's inputs still applied.

// File: rtl/isr_pkg.sv
package isr_pkg;
    localparam int STAT_W  = 8;
    localparam int NSRC    = 2;
    localparam int IRQ_POS = 7;
    // source index 0 is the alarm, index 1 the update-ended event
    localparam int SRC_POS [NSRC] = '{5, 4};

    typedef struct packed {
        logic flag;
        logic pend;
    } src_state_t;

    typedef struct packed {
        logic              rd;
        logic [STAT_W-1:0] snap;
    } rd_state_t;
endpackage

// File: rtl/isr_src_latch.sv
module isr_src_latch
    import isr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic rd_stb,
    input  logic clr,
    input  logic snap_bit,
    output logic flag
);
    src_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_stb) begin
            st_d.pend = st_q.pend | evt;
        end else if (clr) begin
            st_d.flag = (st_q.flag & ~snap_bit) | st_q.pend | evt;
            st_d.pend = 1'b0;
        end else begin
            st_d.flag = st_q.flag | evt;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R1
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !rd_stb) |=> flag);
    // R6
    visible_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && snap_bit && !st_q.pend && !evt) |=> !flag);
    // R7
    held_posted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && st_q.pend) |=> flag);
    // R5
    flag_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> $stable(flag));
endmodule

// File: rtl/isr_irq_merge.sv
module isr_irq_merge #(
    parameter int N = 2
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enables,
    output logic         req
);
    always_comb begin
        req = 1'b0;
        for (int i = 0; i < N; i++) begin
            req = req | (flags[i] & enables[i]);
        end
    end
endmodule

// File: rtl/isr_status.sv
module isr_status
    import isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_evt,
    input  logic              upd_evt,
    input  logic              alarm_en,
    input  logic              upd_en,
    input  logic              rd_stb,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic [NSRC-1:0]   evt_v, en_v, flag_v;
    logic [STAT_W-1:0] live;
    logic              req, clr;
    rd_state_t         rs_d, rs_q;

    assign evt_v = {upd_evt, alarm_evt};
    assign en_v  = {upd_en, alarm_en};
    assign clr   = rs_q.rd & ~rd_stb;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        isr_src_latch u_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt_v[s]),
            .rd_stb   (rd_stb),
            .clr      (clr),
            .snap_bit (rs_q.snap[SRC_POS[s]]),
            .flag     (flag_v[s])
        );
    end

    isr_irq_merge #(.N(NSRC)) u_merge (
        .flags   (flag_v),
        .enables (en_v),
        .req     (req)
    );

    always_comb begin
        live = '0;
        live[IRQ_POS] = req;
        for (int s = 0; s < NSRC; s++) begin
            live[SRC_POS[s]] = flag_v[s];
        end
    end

    always_comb begin
        rs_d    = rs_q;
        rs_d.rd = rd_stb;
        if (rd_stb && !rs_q.rd) rs_d.snap = live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign status = rs_q.rd ? rs_q.snap : live;
    assign irq    = req;

    // R2
    irq_follows_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_v[0] && alarm_en) || (flag_v[1] && upd_en)) |-> irq);
    // R2
    irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_v == '0) |-> !irq);
    // R5
    read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> $stable(status));
    // R4
    spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status & 8'b0100_1111) == 8'h00);
endmodule

// File: tb/isr_status_test.sv
module isr_status_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alarm_evt = 1'b0, upd_evt = 1'b0;
    logic       alarm_en = 1'b0, upd_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] status;
    logic       irq;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isr_status uut (
        .clk(clk), .rst_n(rst_n), .alarm_evt(alarm_evt), .upd_evt(upd_evt),
        .alarm_en(alarm_en), .upd_en(upd_en), .rd_stb(rd_stb),
        .status(status), .irq(irq)
    );

    // {alarm_evt, upd_evt, alarm_en, upd_en, rd_stb, status[7:0], irq}
    localparam int NV = 15;
    localparam logic [13:0] VEC [NV] = '{
        {5'b10000, 8'h20, 1'b0},  // R1 alarm with enable low
        {5'b00100, 8'hA0, 1'b1},  // R3 enable on an already set flag
        {5'b01100, 8'hB0, 1'b1},  // R9 both flags
        {5'b00101, 8'hB0, 1'b1},  // R5 capture
        {5'b10101, 8'hB0, 1'b1},  // R7 event held during read
        {5'b00100, 8'hA0, 1'b1},  // R6 R7 clear, held alarm posted
        {5'b00101, 8'hA0, 1'b1},  // R5 capture
        {5'b01100, 8'h10, 1'b0},  // R8 event in clear cycle kept
        {5'b00110, 8'h90, 1'b1},  // R2 update source enabled
        {5'b00011, 8'h90, 1'b1},  // R5
        {5'b00000, 8'h00, 1'b0},  // R6
        {5'b01000, 8'h10, 1'b0},  // R1 update with enable low
        {5'b00001, 8'h10, 1'b0},  // R5
        {5'b00011, 8'h10, 1'b1},  // R5 value frozen, irq live
        {5'b00010, 8'h00, 1'b0}   // R6
    };

    task automatic check(input string req, input logic [7:0] es, input logic ei);
        n_run++;
        if (status !== es || irq !== ei) begin
            n_fail++;
            $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                     req, status, irq, es, ei);
        end
    endtask

    task automatic drive(input logic [4:0] c);
        {alarm_evt, upd_evt, alarm_en, upd_en, rd_stb} = c;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: run=%0d expected completion", n_run);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R10", 8'h00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", 8'h00, 1'b0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][13:9]);
            @(negedge clk);
            check($sformatf("row%0d", i), VEC[i][8:1], VEC[i][0]);
        end

        // R7 long read: event in last strobe-high cycle is posted
        drive(5'b10000); @(negedge clk); check("R1", 8'h20, 1'b0);
        drive(5'b00001); @(negedge clk); check("R5", 8'h20, 1'b0);
        drive(5'b00001); @(negedge clk); check("R5", 8'h20, 1'b0);
        drive(5'b01001); @(negedge clk); check("R7", 8'h20, 1'b0);
        drive(5'b00000); @(negedge clk); check("R7", 8'h10, 1'b0);

        // R6 read of an empty register leaves it empty
        drive(5'b00001); @(negedge clk); check("R5", 8'h10, 1'b0);
        drive(5'b00000); @(negedge clk); check("R6", 8'h00, 1'b0);
        drive(5'b00001); @(negedge clk); check("R6", 8'h00, 1'b0);
        drive(5'b00000); @(negedge clk); check("R6", 8'h00, 1'b0);

        // R10 reset in the middle of a read with a held event
        drive(5'b11111); @(negedge clk);
        rst_n = 1'b0;
        drive(5'b00000);
        @(negedge clk); check("R10", 8'h00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk); check("R10", 8'h00, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule